// File: doc/BRIEF.md
# Acquisition Run-State Controller

This block sequences one sampling acquisition through three run states: stopped, prepared and running. A host side issues prepare requests, which carry a coarse delay count and a word-width flag, and start requests. On the other side it watches the done flag of an external waveform engine. It drives that engine's start trigger and its transaction-count load. It also drives the control strobes of the endpoint FIFO that receives the samples: a hold that NAKs all host traffic, a mode select between automatic IN transfer and manual mode, a word-width select, and a FIFO reset.

A prepare request is acted on only while the engine reports done. The block waits for that flag if needed, and it refuses a coarse delay that is too large. A start request arms a single transaction and fires the engine. The run ends when the engine reports done again while the block is running. The block then takes the FIFO through a fixed five-step flush. Each step holds its strobe pattern for a programmable number of settle cycles, and the block then returns to stopped.

Top module: `acq_runctl`

## Requirements
- R1: After reset `status_o` is 0 (stopped). `fifo_nak_o`, `fifo_auto_o`, `fifo_wide_o` and `fifo_rst_o` are low, and no pulse output is high.
- R2: A prepare request sampled with `eng_done_i` high, in a state other than running, and with a coarse delay below MAX_COARSE gives a one-cycle `prep_ack_o` in the next cycle. In that same cycle `status_o` becomes 1 (prepared), `fifo_auto_o` becomes 1 and `fifo_wide_o` takes the request's width flag.
- R3: A prepare request sampled with `eng_done_i` low is held pending. It completes at the first edge where `eng_done_i` is high and uses the delay and width captured with the request. Further prepare requests are ignored while one is pending.
- R4: A prepare whose coarse delay is MAX_COARSE (6) or more gives a one-cycle `prep_rej_o`. Status and FIFO strobes stay as they were.
- R5: A start request in the prepared state with no prepare pending gives, in the next cycle, a one-cycle pulse on both `eng_trig_o` and `eng_tc_load_o` with `eng_tcount_o` = 1. In that same cycle `status_o` becomes 2 (running).
- R6: A completion is recognised only when the status is running and `eng_done_i` is high. `eng_done_i` high in the stopped or prepared state starts no flush.
- R7: On completion the FIFO strobes {nak, auto, rst} go through five steps in order: (1,auto,0) with the width unchanged, then (1,0,0), then (1,0,1), then (1,1,0), then (0,1,0). Width is 0 from the second step on, and `status_o` stays 2 throughout. The first step appears in the cycle after the completion edge, and each step lasts exactly SETTLE cycles.
- R8: In the cycle after the last step `status_o` is 0. The strobes then rest at nak=0, auto=1, wide=0, rst=0.
- R9: A start request outside the prepared state, or while a prepare is pending, does not change the status. It raises `start_err_o` for one cycle.
- R10: A prepare request while running (flush included) has no effect: no acknowledge, no reject and no change of status.
- R11: If start and prepare are requested in the same cycle in the prepared state, the start is taken and the prepare is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prep_req_i | input | 1 | Prepare request, one cycle |
| prep_coarse_i | input | COARSE_W | Coarse delay count of the prepare |
| prep_wide_i | input | 1 | Prepare selects 16-bit FIFO words |
| start_req_i | input | 1 | Start request, one cycle |
| eng_done_i | input | 1 | Engine idle/done flag |
| eng_trig_o | output | 1 | Engine initial read trigger pulse |
| eng_tc_load_o | output | 1 | Transaction count load pulse |
| eng_tcount_o | output | TC_W | Transaction count value, valid with load |
| fifo_nak_o | output | 1 | NAK-all hold for the endpoint |
| fifo_auto_o | output | 1 | 1 = automatic IN mode, 0 = manual |
| fifo_wide_o | output | 1 | 16-bit word mode select |
| fifo_rst_o | output | 1 | Endpoint FIFO reset strobe |
| status_o | output | 2 | 0 stopped, 1 prepared, 2 running |
| prep_ack_o | output | 1 | Prepare accepted pulse |
| prep_rej_o | output | 1 | Prepare refused pulse |
| start_err_o | output | 1 | Start request refused pulse |

## Verification
The bench builds the controller with SETTLE = 3, MAX_COARSE = 6 and a 3-bit coarse field. A settle window above one therefore shows a step holding its strobes over several cycles and not only at one edge. The 3-bit field also lets the bench drive coarse values 6 and 7, on and above the refusal boundary. Two runs are made, with the width flag clear in one and set in the other. The first flush step shows the width still set in one run and clear in the other before manual mode drops it.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ST_STOPPED  = 2'd0,
    ST_PREPARED = 2'd1,
    ST_RUNNING  = 2'd2
  } run_state_e;

  // Flush steps in the order they are taken after completion.
  typedef enum logic [2:0] {
    FL_IDLE    = 3'd0,
    FL_NAK     = 3'd1,
    FL_MANUAL  = 3'd2,
    FL_CLEAR   = 3'd3,
    FL_AUTO    = 3'd4,
    FL_RELEASE = 3'd5
  } flush_step_e;

  typedef struct packed {
    logic nak;
    logic auto_in;
    logic word;
    logic clr;
  } fifo_ctl_t;

endpackage

// File: rtl/acq_prep_gate.sv
module acq_prep_gate #(
  parameter int COARSE_W   = 3,
  parameter int MAX_COARSE = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                wide_i,
  input  logic                done_i,
  input  logic                allow_i,
  input  logic                drop_i,
  output logic                ok_o,
  output logic                bad_o,
  output logic                wide_o,
  output logic                pend_o
);

  localparam logic [COARSE_W:0] LIMIT = (COARSE_W+1)'(MAX_COARSE);

  logic                pend_q, pend_d;
  logic [COARSE_W-1:0] coarse_q;
  logic                wide_q;
  logic                take;
  logic                park;
  logic                want;
  logic                fire;
  logic [COARSE_W-1:0] sel_coarse;
  logic                sel_wide;
  logic                in_range;

  // A fresh request is considered only when nothing is already pending.
  always_comb begin
    take       = req_i && allow_i && !drop_i && !pend_q;
    park       = take && !done_i;
    want       = pend_q || take;
    fire       = want && done_i;
    sel_coarse = pend_q ? coarse_q : coarse_i;
    sel_wide   = pend_q ? wide_q   : wide_i;
    in_range   = ({1'b0, sel_coarse} < LIMIT);
    pend_d     = pend_q ? !done_i : park;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      wide_q   <= 1'b0;
    end else if (park) begin
      coarse_q <= coarse_i;
      wide_q   <= wide_i;
    end
  end

  assign ok_o   = fire && in_range;
  assign bad_o  = fire && !in_range;
  assign wide_o = sel_wide;
  assign pend_o = pend_q;

endmodule

// File: rtl/acq_flush_seq.sv
module acq_flush_seq
  import acq_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_i,
  input  logic      cfg_load_i,
  input  logic      cfg_wide_i,
  output fifo_ctl_t ctl_o,
  output logic      busy_o,
  output logic      fin_o
);

  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  flush_step_e     step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            seq_en;
  logic            last;
  logic            auto_q, auto_d;
  logic            wide_q, wide_d;
  logic            mode_en;

  assign last   = (cnt_q == CNT_LAST);
  assign busy_o = (step_q != FL_IDLE);
  assign fin_o  = (step_q == FL_RELEASE) && last;
  assign seq_en = busy_o || go_i;

  // Step sequencing: each step holds for SETTLE cycles.
  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    if (step_q == FL_IDLE) begin
      if (go_i) begin
        step_d = FL_NAK;
        cnt_d  = '0;
      end
    end else if (last) begin
      cnt_d = '0;
      unique case (step_q)
        FL_NAK:     step_d = FL_MANUAL;
        FL_MANUAL:  step_d = FL_CLEAR;
        FL_CLEAR:   step_d = FL_AUTO;
        FL_AUTO:    step_d = FL_RELEASE;
        FL_RELEASE: step_d = FL_IDLE;
        default:    step_d = FL_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= FL_IDLE;
      cnt_q  <= '0;
    end else if (seq_en) begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end

  // Resting FIFO mode: set by a prepare, restored to auto/narrow by a flush.
  always_comb begin
    mode_en = cfg_load_i || fin_o;
    auto_d  = 1'b1;
    wide_d  = cfg_load_i ? cfg_wide_i : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      wide_q <= 1'b0;
    end else if (mode_en) begin
      auto_q <= auto_d;
      wide_q <= wide_d;
    end
  end

  // Strobe decode from the registered step.
  always_comb begin
    ctl_o = '{nak: 1'b0, auto_in: auto_q, word: wide_q, clr: 1'b0};
    unique case (step_q)
      FL_NAK:     ctl_o = '{nak: 1'b1, auto_in: auto_q, word: wide_q, clr: 1'b0};
      FL_MANUAL:  ctl_o = '{nak: 1'b1, auto_in: 1'b0,   word: 1'b0,   clr: 1'b0};
      FL_CLEAR:   ctl_o = '{nak: 1'b1, auto_in: 1'b0,   word: 1'b0,   clr: 1'b1};
      FL_AUTO:    ctl_o = '{nak: 1'b1, auto_in: 1'b1,   word: 1'b0,   clr: 1'b0};
      FL_RELEASE: ctl_o = '{nak: 1'b0, auto_in: 1'b1,   word: 1'b0,   clr: 1'b0};
      default:    ctl_o = '{nak: 1'b0, auto_in: auto_q, word: wide_q, clr: 1'b0};
    endcase
  end

endmodule

// File: rtl/acq_run_fsm.sv
module acq_run_fsm
  import acq_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            done_i,
  input  logic            pend_i,
  input  logic            prep_ok_i,
  input  logic            prep_bad_i,
  input  logic            flush_busy_i,
  input  logic            flush_fin_i,
  output run_state_e      state_o,
  output logic            start_ok_o,
  output logic            flush_go_o,
  output logic            trig_o,
  output logic            tc_load_o,
  output logic [TC_W-1:0] tcount_o,
  output logic            start_err_o,
  output logic            prep_ack_o,
  output logic            prep_rej_o
);

  localparam logic [TC_W-1:0] ONE_TXN = TC_W'(1);

  run_state_e      state_q, state_d;
  logic            start_ok;
  logic            state_en;
  logic            trig_q, err_q, ack_q, rej_q;
  logic [TC_W-1:0] tc_q, tc_d;

  always_comb begin
    start_ok   = start_i && (state_q == ST_PREPARED) && !pend_i;
    flush_go_o = (state_q == ST_RUNNING) && done_i && !flush_busy_i;
  end

  // Next state; start and flush end are exclusive by state.
  always_comb begin
    state_d = state_q;
    if (start_ok) begin
      state_d = ST_RUNNING;
    end else if (flush_fin_i) begin
      state_d = ST_STOPPED;
    end else if (prep_ok_i) begin
      state_d = ST_PREPARED;
    end
    state_en = start_ok || flush_fin_i || prep_ok_i;
    tc_d     = start_ok ? ONE_TXN : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      tc_q   <= '0;
      err_q  <= 1'b0;
      ack_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      trig_q <= start_ok;
      tc_q   <= tc_d;
      err_q  <= start_i && !start_ok;
      ack_q  <= prep_ok_i;
      rej_q  <= prep_bad_i;
    end
  end

  assign state_o     = state_q;
  assign start_ok_o  = start_ok;
  assign trig_o      = trig_q;
  assign tc_load_o   = trig_q;
  assign tcount_o    = tc_q;
  assign start_err_o = err_q;
  assign prep_ack_o  = ack_q;
  assign prep_rej_o  = rej_q;

endmodule

// File: rtl/acq_runctl.sv
module acq_runctl
  import acq_pkg::*;
#(
  parameter int COARSE_W   = 3,
  parameter int MAX_COARSE = 6,
  parameter int TC_W       = 16,
  parameter int SETTLE     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prep_req_i,
  input  logic [COARSE_W-1:0] prep_coarse_i,
  input  logic                prep_wide_i,
  input  logic                start_req_i,
  input  logic                eng_done_i,
  output logic                eng_trig_o,
  output logic                eng_tc_load_o,
  output logic [TC_W-1:0]     eng_tcount_o,
  output logic                fifo_nak_o,
  output logic                fifo_auto_o,
  output logic                fifo_wide_o,
  output logic                fifo_rst_o,
  output logic [1:0]          status_o,
  output logic                prep_ack_o,
  output logic                prep_rej_o,
  output logic                start_err_o
);

  run_state_e state;
  fifo_ctl_t  ctl;
  logic       prep_ok, prep_bad, prep_wide, prep_pend;
  logic       start_ok, flush_go, flush_busy, flush_fin;
  logic       allow_prep;

  assign allow_prep = (state != ST_RUNNING);

  acq_prep_gate #(
    .COARSE_W  (COARSE_W),
    .MAX_COARSE(MAX_COARSE)
  ) gate_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (prep_req_i),
    .coarse_i(prep_coarse_i),
    .wide_i  (prep_wide_i),
    .done_i  (eng_done_i),
    .allow_i (allow_prep),
    .drop_i  (start_ok),
    .ok_o    (prep_ok),
    .bad_o   (prep_bad),
    .wide_o  (prep_wide),
    .pend_o  (prep_pend)
  );

  acq_run_fsm #(
    .TC_W(TC_W)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_req_i),
    .done_i      (eng_done_i),
    .pend_i      (prep_pend),
    .prep_ok_i   (prep_ok),
    .prep_bad_i  (prep_bad),
    .flush_busy_i(flush_busy),
    .flush_fin_i (flush_fin),
    .state_o     (state),
    .start_ok_o  (start_ok),
    .flush_go_o  (flush_go),
    .trig_o      (eng_trig_o),
    .tc_load_o   (eng_tc_load_o),
    .tcount_o    (eng_tcount_o),
    .start_err_o (start_err_o),
    .prep_ack_o  (prep_ack_o),
    .prep_rej_o  (prep_rej_o)
  );

  acq_flush_seq #(
    .SETTLE(SETTLE)
  ) flush_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (flush_go),
    .cfg_load_i(prep_ok),
    .cfg_wide_i(prep_wide),
    .ctl_o     (ctl),
    .busy_o    (flush_busy),
    .fin_o     (flush_fin)
  );

  assign fifo_nak_o  = ctl.nak;
  assign fifo_auto_o = ctl.auto_in;
  assign fifo_wide_o = ctl.word;
  assign fifo_rst_o  = ctl.clr;
  assign status_o    = state;

endmodule

// File: rtl/acq_runctl_chk.sv
module acq_runctl_chk #(
  parameter int TC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eng_trig_o,
  input logic            eng_tc_load_o,
  input logic [TC_W-1:0] eng_tcount_o,
  input logic            fifo_nak_o,
  input logic            fifo_auto_o,
  input logic            fifo_wide_o,
  input logic            fifo_rst_o,
  input logic [1:0]      status_o,
  input logic            prep_ack_o,
  input logic            prep_rej_o,
  input logic            start_err_o
);

  AST_CLEAR_UNDER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rst_o) |-> fifo_nak_o && $past(fifo_nak_o)); // R7

  AST_CLEAR_IN_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst_o |-> !fifo_auto_o && !fifo_wide_o); // R7

  AST_NAK_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_nak_o |-> status_o == 2'd2); // R7

  AST_TRIG_FROM_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_trig_o |-> status_o == 2'd2 && $past(status_o) == 2'd1); // R5

  AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tc_load_o |-> eng_tcount_o == TC_W'(1) && eng_trig_o); // R5

  AST_ACK_PREPARED: assert property (@(posedge clk) disable iff (!rst_n)
    prep_ack_o |-> status_o == 2'd1 && fifo_auto_o); // R2

  AST_REJ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    prep_rej_o |-> $stable(status_o) && !prep_ack_o); // R4

  AST_ERR_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    start_err_o |-> !eng_trig_o); // R9

  AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 2'd2 && status_o == 2'd0) |->
      !fifo_nak_o && fifo_auto_o && !fifo_wide_o && !fifo_rst_o); // R8

endmodule

bind acq_runctl acq_runctl_chk #(.TC_W(TC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_trig_o   (eng_trig_o),
  .eng_tc_load_o(eng_tc_load_o),
  .eng_tcount_o (eng_tcount_o),
  .fifo_nak_o   (fifo_nak_o),
  .fifo_auto_o  (fifo_auto_o),
  .fifo_wide_o  (fifo_wide_o),
  .fifo_rst_o   (fifo_rst_o),
  .status_o     (status_o),
  .prep_ack_o   (prep_ack_o),
  .prep_rej_o   (prep_rej_o),
  .start_err_o  (start_err_o)
);

// File: tb/acq_runctl_tb_top.sv
`timescale 1ns/1ps
module acq_runctl_tb_top;

  localparam int CW = 3;
  localparam int MAXC = 6;
  localparam int TCW = 16;
  localparam int S = 3;

  logic clk, rst_n;
  logic prep_req, prep_wide, start_req, done;
  logic [CW-1:0] prep_coarse;
  logic trig, tcl, nak, autom, wide, frst, ack, rej, serr;
  logic [TCW-1:0] tcount;
  logic [1:0] status;

  acq_runctl #(.COARSE_W(CW), .MAX_COARSE(MAXC), .TC_W(TCW), .SETTLE(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .prep_req_i(prep_req), .prep_coarse_i(prep_coarse),
    .prep_wide_i(prep_wide), .start_req_i(start_req), .eng_done_i(done),
    .eng_trig_o(trig), .eng_tc_load_o(tcl), .eng_tcount_o(tcount),
    .fifo_nak_o(nak), .fifo_auto_o(autom), .fifo_wide_o(wide), .fifo_rst_o(frst),
    .status_o(status), .prep_ack_o(ack), .prep_rej_o(rej), .start_err_o(serr));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_status, m_fl, m_wc;
  bit m_wait, m_ww, m_nak, m_auto, m_wide, m_rst;
  bit m_ack, m_rej, m_err, m_trig;

  task automatic check(string t, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", t, nm, act, exp);
    end
  endtask

  task automatic phase(int k);
    case (k)
      0: begin m_nak = 1; m_rst = 0; end
      1: begin m_nak = 1; m_auto = 0; m_wide = 0; m_rst = 0; end
      2: begin m_nak = 1; m_auto = 0; m_wide = 0; m_rst = 1; end
      3: begin m_nak = 1; m_auto = 1; m_wide = 0; m_rst = 0; end
      default: begin m_nak = 0; m_auto = 1; m_wide = 0; m_rst = 0; end
    endcase
  endtask

  task automatic apply_prep(int c, bit w);
    if (c >= MAXC) m_rej = 1;
    else begin
      m_ack = 1; m_status = 1; m_auto = 1; m_wide = w;
    end
  endtask

  task automatic model_step();
    int os = m_status;
    bit ow = m_wait;
    bit sok;
    m_ack = 0; m_rej = 0; m_err = 0; m_trig = 0;
    sok = start_req && os == 1 && !ow;
    if (start_req && !sok) m_err = 1;
    if (sok) begin m_trig = 1; m_status = 2; end
    if (m_fl > 0) begin
      m_fl++;
      if (m_fl > 5 * S) begin
        m_fl = 0; m_status = 0; phase(4);
      end else phase((m_fl - 1) / S);
    end else if (os == 2 && done) begin
      m_fl = 1; phase(0);
    end
    if (os != 2 && !sok) begin
      if (ow) begin
        if (done) begin m_wait = 0; apply_prep(m_wc, m_ww); end
      end else if (prep_req) begin
        if (done) apply_prep(prep_coarse, prep_wide);
        else begin m_wait = 1; m_wc = prep_coarse; m_ww = prep_wide; end
      end
    end
  endtask

  task automatic compare_all();
    check(tag, "status_o", status, m_status);
    check(tag, "fifo_nak_o", nak, m_nak);
    check(tag, "fifo_auto_o", autom, m_auto);
    check(tag, "fifo_wide_o", wide, m_wide);
    check(tag, "fifo_rst_o", frst, m_rst);
    check(tag, "prep_ack_o", ack, m_ack);
    check(tag, "prep_rej_o", rej, m_rej);
    check(tag, "start_err_o", serr, m_err);
    check(tag, "eng_trig_o", trig, m_trig);
    check(tag, "eng_tc_load_o", tcl, m_trig);
    check(tag, "eng_tcount_o", tcount, m_trig ? 1 : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic prep(int c, bit w);
    prep_req = 1; prep_coarse = CW'(c); prep_wide = w;
    tick();
    prep_req = 0;
  endtask

  task automatic start();
    start_req = 1;
    tick();
    start_req = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    bit en [5][3];
    rst_n = 0; prep_req = 0; prep_coarse = '0; prep_wide = 0; start_req = 0; done = 1;
    m_status = 0; m_fl = 0; m_wc = 0; m_wait = 0; m_ww = 0;
    m_nak = 0; m_auto = 0; m_wide = 0; m_rst = 0;
    m_ack = 0; m_rej = 0; m_err = 0; m_trig = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare_all();
    rst_n = 1;
    repeat (2) tick();

    tag = "R9"; start();                       // start while stopped
    check("R9", "start_err_o", serr, 1);
    tag = "R6"; repeat (3) tick();             // done high, stopped: no flush
    check("R6", "fifo_nak_o", nak, 0);

    tag = "R4"; prep(7, 1); check("R4", "prep_rej_o", rej, 1);
    prep(6, 0); check("R4", "status_o", status, 0);
    check("R4", "fifo_auto_o", autom, 0);

    tag = "R2"; prep(5, 1);
    check("R2", "status_o", status, 1);
    check("R2", "fifo_wide_o", wide, 1);
    tag = "R6"; repeat (2) tick();

    tag = "R3"; done = 0;
    prep(2, 0); tick();
    check("R3", "prep_ack_o", ack, 0);
    prep(7, 1);                                // ignored while pending
    tag = "R9"; start(); check("R9", "status_o", status, 1);
    tag = "R3"; done = 1; tick();
    check("R3", "prep_ack_o", ack, 1);
    check("R3", "fifo_wide_o", wide, 0);

    tag = "R11"; prep_req = 1; prep_coarse = 7; start_req = 1; done = 0;
    tick(); prep_req = 0; start_req = 0;
    check("R11", "prep_rej_o", rej, 0);
    check("R5", "eng_tcount_o", tcount, 1);
    check("R5", "status_o", status, 2);

    tag = "R10"; prep(1, 1); check("R10", "prep_ack_o", ack, 0);
    tag = "R9"; start(); check("R9", "start_err_o", serr, 1);
    tag = "R6"; repeat (3) tick(); check("R6", "fifo_nak_o", nak, 0);

    // Completion and explicit flush order check (rows: nak, auto, rst)
    en[0] = '{1, 1, 0}; en[1] = '{1, 0, 0}; en[2] = '{1, 0, 1};
    en[3] = '{1, 1, 0}; en[4] = '{0, 1, 0};
    tag = "R7"; done = 1; tick();
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < S; c++) begin
        check("R7", "fifo_nak_o", nak, en[k][0]);
        check("R7", "fifo_auto_o", autom, en[k][1]);
        check("R7", "fifo_rst_o", frst, en[k][2]);
        check("R7", "status_o", status, 2);
        tick();
      end
    end
    tag = "R8";
    check("R8", "status_o", status, 0);
    check("R8", "fifo_auto_o", autom, 1);
    check("R8", "fifo_wide_o", wide, 0);
    tag = "R6"; repeat (3) tick(); check("R6", "fifo_nak_o", nak, 0);

    // Second run, wide mode, done stays high through start
    tag = "R2"; prep(0, 1);
    tag = "R5"; start();
    tag = "R7"; repeat (5 * S + 1) tick();
    tag = "R8"; check("R8", "status_o", status, 0);
    repeat (2) tick();
    summary();
  end

endmodule